// File: doc/BRIEF.md
# TDM Serial Audio Port (Slave)

This block is the serial side of a multichannel audio converter that runs from clocks supplied by the system. A bit clock runs at 256 times the frame rate, and a frame-sync input rises once per frame. Each frame holds eight 32-bit time slots. The incoming serial line carries eight playback samples, one per slot. The outgoing line carries six capture samples in slots 0 to 5. Slots 6 and 7 are sent as zero.

The frame starts one bit clock late. The most significant bit of slot 0 is the bit present at the second rising edge after the frame-sync rises. All bits travel MSB first. Each sample sits left-justified in its slot, and a two-bit length select picks 16, 18, 20 or 24 valid bits. Received bits are sampled on rising edges. Transmitted bits change on falling edges, except for the first bit of a frame, which is driven early.

After the last bit of a frame, all eight received words appear together, marked by a one-cycle strobe. If a frame-sync arrives at the wrong count, the block raises a sticky error flag and realigns to that frame-sync.

Top module: `tdm_slave_port`

## Requirements
- R1: While reset is held and right after it, `frame_done`, `framing_err`, `sdout` and every bit of `dac_words` are 0.
- R2: A frame-sync rise is seen at rising edge E0. The `sdin` value at the next rising edge is bit 31 (MSB) of slot 0. The following 255 rising edges carry the remaining bits MSB first, 32 per slot, for slots 0 to 7. Slot k is delivered on `dac_words[k*24 +: 24]`.
- R3: `frame_done` is a one-cycle pulse. It follows the rising edge that samples the 256th bit of a frame, and all eight words in `dac_words` change together with it.
- R4: `len_sel` selects the valid length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. It is captured at each frame start. A received word holds the first len bits of its slot in its top bits, and its lower bits are 0.
- R5: Bit j of the frame on `sdout` changes on the falling edge that precedes the rising edge at which bit j of `sdin` is sampled. For slot s in 0 to 5 and bit position b below len, `sdout` carries bit 23-b of `adc_words[s*24 +: 24]`. Bit positions at or beyond len carry 0.
- R6: During slots 6 and 7, `sdout` is 0.
- R7: `adc_words` is captured at the frame-start edge E0. A change to it later in the frame does not alter the bits sent in that frame.
- R8: The MSB of slot 0 appears on `sdout` from edge E0 onward. It stays there through the next rising edge, ahead of the normal falling-edge timing.
- R9: A frame-sync rise that comes after alignment, at any count other than 256 cycles after the previous frame start, sets `framing_err`. The flag stays set until reset. The frame counting restarts at that frame-sync, and any partly received frame gives no `frame_done`.
- R10: Before the first frame-sync rise, `frame_done` stays 0 and `sdout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Bit clock, 256 cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync; its rising edge marks a frame start |
| sdin | input | 1 | Serial playback data, sampled on rising edges |
| len_sel | input | 2 | Valid sample length select (16/18/20/24) |
| adc_words | input | 144 | Six capture samples, slot k at bits k*24 +: 24 |
| sdout | output | 1 | Serial capture data |
| dac_words | output | 192 | Eight received samples, slot k at bits k*24 +: 24 |
| frame_done | output | 1 | One-cycle strobe when a full frame is received |
| framing_err | output | 1 | Sticky flag for a mistimed frame sync |

## Verification
The edge that samples the last bit of one frame also detects the next frame-sync. At that same edge the block captures new capture words and a new length, and it starts the early MSB. The bench drives frames back to back and changes `len_sel` and `adc_words` at each boundary. The scoreboard then confirms that each finished frame is trimmed with the length captured at its own start, and that the first `sdout` bit after that edge already comes from the new words. A short frame followed by a full one makes a misaligned frame-sync coincide with a partly filled frame. The bench checks that this frame gives no strobe, that the flag rises, and that the next frame arrives intact.

// File: rtl/tdm_slave_pkg.sv
package tdm_slave_pkg;

    typedef enum logic [1:0] {
        LEN_16 = 2'd0,
        LEN_18 = 2'd1,
        LEN_20 = 2'd2,
        LEN_24 = 2'd3
    } len_sel_e;

    // Number of valid leading bits for each length code.
    function automatic int unsigned len_bits(input len_sel_e sel);
        case (sel)
            LEN_16:  return 16;
            LEN_18:  return 18;
            LEN_20:  return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_slave_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 256,
    localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             fs,
    input  logic [1:0]       len_sel,
    output logic             frame_start,
    output logic             aligned,
    output logic [IDX_W-1:0] bit_idx,
    output len_sel_e         len_cur,
    output logic             framing_err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             fs_prev;
        logic             aligned;
        logic [IDX_W-1:0] idx;
        len_sel_e         len;
        logic             err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fs;
        frame_start  = fs & ~st_q.fs_prev;
        if (frame_start) begin
            // A sync at any count other than the frame end breaks alignment.
            if (st_q.aligned && (st_q.idx != LAST_IDX)) begin
                st_d.err = 1'b1;
            end
            st_d.aligned = 1'b1;
            st_d.idx     = '0;
            st_d.len     = len_sel_e'(len_sel);
        end else if (st_q.aligned) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aligned     = st_q.aligned;
    assign bit_idx     = st_q.idx;
    assign len_cur     = st_q.len;
    assign framing_err = st_q.err;

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_slave_pkg::*;
#(
    parameter int unsigned SLOTS    = 8,
    parameter int unsigned SLOT_W   = 32,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned IDX_W    = 8
) (
    input  logic                      sclk,
    input  logic                      rst_n,
    input  logic                      aligned,
    input  logic [IDX_W-1:0]          bit_idx,
    input  len_sel_e                  len_cur,
    input  logic                      sdin,
    output logic [SLOTS*SAMPLE_W-1:0] words,
    output logic                      done
);

    localparam int unsigned BIT_W = $clog2(SLOT_W);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        logic [SLOTS-1:0][SAMPLE_W-1:0] work;
        logic [SLOTS-1:0][SAMPLE_W-1:0] held;
        logic                           done;
    } rx_t;

    rx_t rx_d, rx_q;

    logic [IDX_W-BIT_W-1:0] slot;
    logic [BIT_W-1:0]       pos;
    int unsigned            valid_len;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        slot      = bit_idx[IDX_W-1:BIT_W];
        pos       = bit_idx[BIT_W-1:0];
        valid_len = len_bits(len_cur);
        if (aligned) begin
            if (pos == '0) begin
                rx_d.work[slot] = '0;
            end
            for (int k = 0; k < SAMPLE_W; k++) begin
                if ((int'(pos) == k) && (k < int'(valid_len))) begin
                    rx_d.work[slot][SAMPLE_W-1-k] = sdin;
                end
            end
            if (bit_idx == LAST_IDX) begin
                rx_d.held = rx_d.work;
                rx_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign words = rx_q.held;
    assign done  = rx_q.done;

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_slave_pkg::*;
#(
    parameter int unsigned SLOTS    = 6,
    parameter int unsigned SLOT_W   = 32,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned IDX_W    = 8
) (
    input  logic                      sclk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      aligned,
    input  logic [IDX_W-1:0]          bit_idx,
    input  len_sel_e                  len_cur,
    input  logic [SLOTS*SAMPLE_W-1:0] adc_words,
    output logic                      sdout
);

    localparam int unsigned BIT_W = $clog2(SLOT_W);

    typedef struct packed {
        logic [SLOTS-1:0][SAMPLE_W-1:0] bank;
        logic                           early;
        logic                           early_bit;
    } tx_t;

    tx_t  tx_d, tx_q;
    logic bit_d, bit_q;

    logic [IDX_W-BIT_W-1:0] slot;
    logic [BIT_W-1:0]       pos;
    int unsigned            valid_len;

    // Rising-edge part: latch the words and launch the early first bit.
    always_comb begin
        tx_d       = tx_q;
        tx_d.early = frame_start;
        if (frame_start) begin
            tx_d.bank      = adc_words;
            tx_d.early_bit = adc_words[SAMPLE_W-1];
        end
    end

    // Falling-edge part: bit for the index sampled at the next rising edge.
    always_comb begin
        bit_d     = 1'b0;
        slot      = bit_idx[IDX_W-1:BIT_W];
        pos       = bit_idx[BIT_W-1:0];
        valid_len = len_bits(len_cur);
        if (aligned && (int'(slot) < SLOTS)) begin
            for (int k = 0; k < SAMPLE_W; k++) begin
                if ((int'(pos) == k) && (k < int'(valid_len))) begin
                    bit_d = tx_q.bank[slot][SAMPLE_W-1-k];
                end
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign sdout = tx_q.early ? tx_q.early_bit : bit_q;

endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port
    import tdm_slave_pkg::*;
#(
    parameter int unsigned RX_SLOTS = 8,
    parameter int unsigned TX_SLOTS = 6,
    parameter int unsigned SLOT_W   = 32,
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                         sclk,
    input  logic                         rst_n,
    input  logic                         fs,
    input  logic                         sdin,
    input  logic [1:0]                   len_sel,
    input  logic [TX_SLOTS*SAMPLE_W-1:0] adc_words,
    output logic                         sdout,
    output logic [RX_SLOTS*SAMPLE_W-1:0] dac_words,
    output logic                         frame_done,
    output logic                         framing_err
);

    localparam int unsigned FRAME_BITS = RX_SLOTS * SLOT_W;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    logic             frame_start;
    logic             aligned;
    logic [IDX_W-1:0] bit_idx;
    len_sel_e         len_cur;

    tdm_frame_ctrl #(
        .FRAME_BITS (FRAME_BITS)
    ) u_ctrl (
        .sclk        (sclk),
        .rst_n       (rst_n),
        .fs          (fs),
        .len_sel     (len_sel),
        .frame_start (frame_start),
        .aligned     (aligned),
        .bit_idx     (bit_idx),
        .len_cur     (len_cur),
        .framing_err (framing_err)
    );

    tdm_rx_deser #(
        .SLOTS    (RX_SLOTS),
        .SLOT_W   (SLOT_W),
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_rx (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .aligned (aligned),
        .bit_idx (bit_idx),
        .len_cur (len_cur),
        .sdin    (sdin),
        .words   (dac_words),
        .done    (frame_done)
    );

    tdm_tx_ser #(
        .SLOTS    (TX_SLOTS),
        .SLOT_W   (SLOT_W),
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_tx (
        .sclk        (sclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .aligned     (aligned),
        .bit_idx     (bit_idx),
        .len_cur     (len_cur),
        .adc_words   (adc_words),
        .sdout       (sdout)
    );

endmodule

// File: rtl/tdm_slave_port_chk.sv
module tdm_slave_port_chk #(
    parameter int unsigned FRAME_BITS = 256,
    parameter int unsigned SLOT_W     = 32,
    parameter int unsigned TX_SLOTS   = 6
) (
    input logic sclk,
    input logic rst_n,
    input logic fs,
    input logic sdout,
    input logic frame_done,
    input logic framing_err
);

    localparam int unsigned IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(FRAME_BITS - 1);

    logic             fs_prev_c;
    logic             seen_c;
    logic [IDX_W-1:0] cnt_c;
    logic             fs_edge_c;
    logic             idle_slot_c;

    assign fs_edge_c   = fs & ~fs_prev_c;
    assign idle_slot_c = (int'(cnt_c) / SLOT_W) >= TX_SLOTS;

    // Independent count of cycles since the last frame-sync rise.
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev_c <= 1'b0;
            seen_c    <= 1'b0;
            cnt_c     <= '0;
        end else begin
            fs_prev_c <= fs;
            if (fs_edge_c) begin
                seen_c <= 1'b1;
                cnt_c  <= '0;
            end else if (seen_c) begin
                cnt_c <= cnt_c + 1'b1;
            end
        end
    end

    p_done_pulse_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_at_frame_end_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        frame_done |-> ($past(cnt_c) == LAST_C));

    p_err_sticky_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        framing_err |=> framing_err);

    p_err_on_mistimed_sync_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (fs_edge_c && seen_c && (cnt_c != LAST_C)) |=> framing_err);

    p_idle_slots_zero_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (seen_c && idle_slot_c) |-> (sdout == 1'b0));

    p_silent_before_sync_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        !seen_c |-> (!frame_done && (sdout == 1'b0)));

endmodule

bind tdm_slave_port tdm_slave_port_chk #(
    .FRAME_BITS (FRAME_BITS),
    .SLOT_W     (SLOT_W),
    .TX_SLOTS   (TX_SLOTS)
) u_chk (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .fs          (fs),
    .sdout       (sdout),
    .frame_done  (frame_done),
    .framing_err (framing_err)
);

// File: tb/tdm_slave_port_test.sv
module tdm_slave_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int RX_SLOTS   = 8;
    localparam int TX_SLOTS   = 6;
    localparam int SAMPLE_W   = 24;
    localparam int RXW        = RX_SLOTS * SAMPLE_W;
    localparam int TXW        = TX_SLOTS * SAMPLE_W;

    logic           sclk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fs = 1'b0;
    logic           sdin = 1'b0;
    logic [1:0]     len_sel = 2'd3;
    logic [TXW-1:0] adc_words = '0;
    logic           sdout;
    logic [RXW-1:0] dac_words;
    logic           frame_done;
    logic           framing_err;

    int checks = 0;
    int errors = 0;
    logic last_bit = 1'b0;
    logic [RXW-1:0] exp_q[$];

    tdm_slave_port uut (
        .sclk        (sclk),
        .rst_n       (rst_n),
        .fs          (fs),
        .sdin        (sdin),
        .len_sel     (len_sel),
        .adc_words   (adc_words),
        .sdout       (sdout),
        .dac_words   (dac_words),
        .frame_done  (frame_done),
        .framing_err (framing_err)
    );

    always #(CLK_PERIOD/2) sclk = ~sclk;

    task automatic check(input bit ok, input string tag,
                         input logic [RXW-1:0] got, input logic [RXW-1:0] want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    // Drives one frame of nbits cycles; i-th pass is the falling edge before E_i.
    task automatic run_frame(input int nbits, input logic [1:0] lsel, input int seed,
                             input bit mid_change, input bit expect_done);
        logic [31:0]         rx_slot [RX_SLOTS];
        logic [SAMPLE_W-1:0] tx_w [TX_SLOTS];
        logic [TXW-1:0]      tx_flat;
        logic [RXW-1:0]      exp_flat;
        logic [SAMPLE_W-1:0] mask;
        int len, bad, bad_idx;
        logic bad_got, bad_want;
        len = len_of(lsel);
        bad = 0; bad_idx = 0; bad_got = 1'b0; bad_want = 1'b0;
        for (int k = 0; k < RX_SLOTS; k++) begin
            rx_slot[k] = (32'(seed) * 32'h9E3779B1) ^ (32'(k + 1) * 32'h85EBCA6B) ^ 32'h5A5A0F0F;
        end
        for (int k = 0; k < TX_SLOTS; k++) begin
            tx_w[k] = SAMPLE_W'((rx_slot[k] * 32'h2545F491) >> 5);
            tx_flat[k*SAMPLE_W +: SAMPLE_W] = tx_w[k];
        end
        tx_w[0][SAMPLE_W-1] = 1'b1;
        tx_flat[SAMPLE_W-1] = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk); #1;
            if (i >= 1) begin
                int j, s, b;
                logic want;
                j = i - 1; s = j / 32; b = j % 32;
                want = (s < TX_SLOTS && b < len) ? tx_w[s][SAMPLE_W-1-b] : 1'b0;
                if (sdout !== want && bad == 0) begin
                    bad_idx = j; bad_got = sdout; bad_want = want;
                end
                if (sdout !== want) bad++;
            end
            fs = (i == 0);
            if (i == 0) begin
                sdin      = last_bit;
                len_sel   = lsel;
                adc_words = tx_flat;
            end else begin
                sdin = rx_slot[(i-1)/32][31 - ((i-1) % 32)];
            end
            if (mid_change && i == 100) adc_words = ~tx_flat;
            if (i == 0) begin
                @(posedge sclk); #1;
                check(sdout === tx_w[0][SAMPLE_W-1], "R8 early slot-0 MSB after frame-start edge",
                      RXW'(sdout), RXW'(tx_w[0][SAMPLE_W-1]));
            end
        end
        check(bad == 0, mid_change ? "R7 R5 R6 tx bits (words changed mid-frame)" : "R5 R6 tx bits",
              RXW'({bad_idx, bad_got}), RXW'({bad_idx, bad_want}));
        last_bit = rx_slot[(nbits-1)/32][31 - ((nbits-1) % 32)];
        mask = ~({SAMPLE_W{1'b1}} >> len);
        for (int k = 0; k < RX_SLOTS; k++) begin
            exp_flat[k*SAMPLE_W +: SAMPLE_W] = rx_slot[k][31 -: SAMPLE_W] & mask;
        end
        if (expect_done) exp_q.push_back(exp_flat);
    endtask

    // Scoreboard monitor: every strobe pops one expected frame.
    initial begin
        forever begin
            @(posedge sclk); #1;
            if (frame_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R9 strobe without a complete frame", RXW'(1), RXW'(0));
                end else begin
                    logic [RXW-1:0] e;
                    e = exp_q.pop_front();
                    check(dac_words === e, "R2 R3 R4 received words", dac_words, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int idle_bad;
        repeat (3) @(negedge sclk);
        #1;
        check(frame_done === 1'b0 && framing_err === 1'b0 && sdout === 1'b0 && dac_words === '0,
              "R1 reset state", {dac_words[RXW-4:0], frame_done, framing_err, sdout}, '0);
        rst_n = 1'b1;

        // R10: no frame sync yet, busy data line.
        idle_bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge sclk); #1;
            sdin = i[0];
            adc_words = '1;
            if (sdout !== 1'b0) idle_bad++;
        end
        check(idle_bad == 0, "R10 sdout idle before first sync", RXW'(idle_bad), '0);

        run_frame(256, 2'd3, 1, 1'b0, 1'b1);
        run_frame(256, 2'd0, 2, 1'b1, 1'b1);
        run_frame(256, 2'd1, 3, 1'b0, 1'b1);
        run_frame(256, 2'd2, 4, 1'b0, 1'b1);
        check(framing_err === 1'b0, "R9 no error on regular frames", RXW'(framing_err), '0);

        run_frame(100, 2'd3, 5, 1'b0, 1'b0);
        run_frame(256, 2'd3, 6, 1'b0, 1'b1);
        check(framing_err === 1'b1, "R9 error after short frame", RXW'(framing_err), RXW'(1));
        run_frame(256, 2'd0, 7, 1'b0, 1'b1);
        check(framing_err === 1'b1, "R9 error flag stays set", RXW'(framing_err), RXW'(1));

        @(negedge sclk); #1;
        fs   = 1'b0;
        sdin = last_bit;
        repeat (4) @(negedge sclk);
        #1;
        check(exp_q.size() == 0, "R3 every full frame strobed", RXW'(exp_q.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule